// File: doc/BRIEF.md
# Link Integrity Pulse and Negotiation Burst Generator

This block drives the transmit-side link pulses seen on an idle twisted-pair link. In the single-pulse mode it sends one short pulse at the start of every 16 ms frame. This keeps the far end's link monitor satisfied. In the negotiation mode it sends a burst at the start of every frame instead. The burst carries a 16-bit code word as a train of 17 clock pulses, 125 µs apart. A data pulse sits 62 µs after a clock pulse when the matching bit is 1. Bits go out least significant first, so bit k belongs to the gap after clock pulse k.

The frame timer runs while the enable is high. At each frame start the generator samples the mode select and the code word, and holds both for that frame. Dropping the enable lets the frame in flight run to its end, including any burst, and then keeps the output low. A one-cycle strobe marks the end of every burst. Every interval is derived from a clock-frequency parameter and rounded to the nearest cycle. Receiving pulses and arbitrating the negotiation belong to other blocks.

Top module: `lpg_link_pulse_gen`

## Requirements
- R1: Every pulse on `pulse_o` is high for PW consecutive cycles, where PW is 100 ns rounded to the nearest clock cycle and never less than one. Both outputs are low while reset is held.
- R2: With `mode_i`=0 sampled at frame start, the frame carries exactly one pulse, at its start, and `burst_done_o` stays low.
- R3: With `mode_i`=1 sampled at frame start, the frame carries 17 clock pulses. The first is at the frame start and the rest follow at 125 µs spacing.
- R4: For k=0..15, bit k of the code word (bit 0 is the least significant) set to 1 adds a pulse 62 µs after clock pulse k. A 0 bit leaves that slot empty.
- R5: While enabled, frames start exactly every 16 ms, measured as pulse rise to pulse rise, in either mode and across a mode change.
- R6: `burst_done_o` is high for exactly one cycle per burst. It rises PW cycles after the 17th clock pulse rises, in the cycle that pulse falls.
- R7: The code word and the mode are sampled only at frame start. Changes during a burst do not alter that burst.
- R8: When `en_i` goes low, the frame in flight completes, burst included, and no further pulse or strobe follows. When `en_i` rises from idle, the first pulse rises two cycles later.
- R9: All intervals come from the parameter CLK_HZ. A count of t ns becomes round(t*CLK_HZ/1e9) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at CLK_HZ |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Allow new frames to start |
| mode_i | input | 1 | 0 single pulse per frame, 1 negotiation burst per frame |
| code_word_i | input | 16 | Code word sent in a burst, bit 0 first |
| pulse_o | output | 1 | Link pulse output |
| burst_done_o | output | 1 | One-cycle strobe after the last clock pulse of a burst |

## Verification
A wrong frame counter shows as frame-to-frame spacing off 16 ms, and this is visible at the second pulse after enable. A wrong slot counter or bit index moves or drops a data pulse within 62 µs of the error. It can also put a data bit on the wrong clock gap, which only sweeping a single set bit through all sixteen positions reveals. A code word latch that follows the input shows up only when the input changes in the middle of a burst. A mishandled enable shows up as pulses appearing during the idle window, which spans two frames after the final burst.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned NUM_CLKP = WORD_W + 1;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_BURST  = 1'b1
  } lpg_mode_e;

  // nanoseconds -> cycles, rounded to nearest, floor of one cycle
  function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd500_000_000) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  // offset of clock pulse k from the start of a burst
  function automatic int unsigned clk_slot(int unsigned k, int unsigned sp);
    return k * sp;
  endfunction

  // offset of the end-of-burst strobe from the start of a burst
  function automatic int unsigned burst_end(int unsigned sp, int unsigned pw);
    return clk_slot(WORD_W, sp) + pw;
  endfunction

endpackage

// File: rtl/lpg_interval_timer.sv
module lpg_interval_timer #(
  parameter int unsigned PERIOD = 400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic frame_start_o
);
  localparam int unsigned CW = $clog2(PERIOD);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          last_cyc;

  assign last_cyc      = (cnt_q == CW'(PERIOD - 1));
  assign frame_start_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      cnt_q <= '0;
      if (en_i) run_q <= 1'b1;
    end else if (last_cyc) begin
      cnt_q <= '0;
      if (!en_i) run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: a running frame wraps into a new frame start when enabled
  p_wrap_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && last_cyc && en_i) |=> frame_start_o);

  // R8: an idle timer with enable low never starts a frame
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !en_i) |=> !frame_start_o);

endmodule

// File: rtl/lpg_burst_seq.sv
module lpg_burst_seq #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned CLK_SP   = 3125,
  parameter int unsigned DATA_OFF = 1550,
  parameter int unsigned PW       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              clk_hit_o,
  output logic              dat_hit_o,
  output logic              done_hit_o,
  output logic              active_o
);
  localparam int unsigned PCW = $clog2(CLK_SP);
  localparam int unsigned IW  = $clog2(WORD_W + 1);
  localparam int unsigned BW  = $clog2(WORD_W);

  logic              active_q;
  logic [PCW-1:0]    pcnt_q;
  logic [IW-1:0]     idx_q;
  logic [WORD_W-1:0] word_q;
  logic              start_burst;
  logic              gap_wrap;
  logic              bit_now;

  assign start_burst = frame_start_i && (mode_i == lpg_pkg::MODE_BURST);
  assign gap_wrap    = (pcnt_q == PCW'(CLK_SP - 1));
  assign bit_now     = word_q[idx_q[BW-1:0]];

  // a frame start always begins with a pulse (single or first clock)
  assign clk_hit_o  = frame_start_i || (active_q && (pcnt_q == '0));
  assign dat_hit_o  = active_q && (pcnt_q == PCW'(DATA_OFF)) &&
                      (idx_q < IW'(WORD_W)) && bit_now;
  assign done_hit_o = active_q && (idx_q == IW'(WORD_W)) && (pcnt_q == PCW'(PW));
  assign active_o   = active_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pcnt_q   <= '0;
      idx_q    <= '0;
      word_q   <= '0;
    end else if (start_burst) begin
      active_q <= 1'b1;
      pcnt_q   <= PCW'(1);
      idx_q    <= '0;
      word_q   <= word_i;
    end else if (active_q) begin
      if (done_hit_o) active_q <= 1'b0;
      if (gap_wrap) begin
        pcnt_q <= '0;
        idx_q  <= idx_q + 1'b1;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  // R3: the clock index never passes the last clock pulse
  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (idx_q <= IW'(WORD_W)));

  // R4: clock and data slots never coincide
  p_slots_apart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clk_hit_o && dat_hit_o));

  // R5: a new frame never starts while a burst is still running
  p_no_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> !active_q);

  // R6: the end strobe closes the burst
  p_done_closes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_hit_o |=> !active_q);

  // R7: the latched word is held for the whole burst
  p_word_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !done_hit_o) |=> $stable(word_q));

endmodule

// File: rtl/lpg_pulse_shaper.sv
module lpg_pulse_shaper #(
  parameter int unsigned PW = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic done_hit_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(PW + 1);

  logic [CW-1:0] left_q;
  logic          done_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_hit_i;
      if (hit_i)               left_q <= CW'(PW);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
    end
  end

  assign pulse_o = (left_q != '0);
  assign done_o  = done_q;

  // R1: a pulse request never lands on a pulse still in progress
  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (left_q == '0));

  // R1: a request raises the output on the next cycle
  p_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> pulse_o);

  // R6: the strobe sits just after the final pulse, never on it
  p_done_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!pulse_o && $fell(pulse_o)));

endmodule

// File: rtl/lpg_link_pulse_gen.sv
module lpg_link_pulse_gen #(
  parameter int unsigned CLK_HZ = 25_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        mode_i,
  input  logic [15:0] code_word_i,
  output logic        pulse_o,
  output logic        burst_done_o
);
  import lpg_pkg::*;

  // R9: every interval derived from the clock frequency
  localparam int unsigned PW       = ns_to_cyc(64'd100,        64'(CLK_HZ));
  localparam int unsigned CLK_SP   = ns_to_cyc(64'd125_000,    64'(CLK_HZ));
  localparam int unsigned DATA_OFF = ns_to_cyc(64'd62_000,     64'(CLK_HZ));
  localparam int unsigned PERIOD   = ns_to_cyc(64'd16_000_000, 64'(CLK_HZ));
  localparam int unsigned SPAN     = burst_end(CLK_SP, PW);

  if (!(PW < DATA_OFF && DATA_OFF + PW < CLK_SP && SPAN < PERIOD)) begin : g_bad_clk
    $error("lpg_link_pulse_gen: CLK_HZ too low for distinct pulse slots");
  end

  logic frame_start;
  logic clk_hit;
  logic dat_hit;
  logic done_hit;
  logic any_hit;
  logic seq_active;

  lpg_interval_timer #(.PERIOD(PERIOD)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .frame_start_o (frame_start)
  );

  lpg_burst_seq #(
    .WORD_W   (WORD_W),
    .CLK_SP   (CLK_SP),
    .DATA_OFF (DATA_OFF),
    .PW       (PW)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .mode_i        (mode_i),
    .word_i        (code_word_i),
    .clk_hit_o     (clk_hit),
    .dat_hit_o     (dat_hit),
    .done_hit_o    (done_hit),
    .active_o      (seq_active)
  );

  assign any_hit = clk_hit || dat_hit;

  lpg_pulse_shaper #(.PW(PW)) u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (any_hit),
    .done_hit_i (done_hit),
    .pulse_o    (pulse_o),
    .done_o     (burst_done_o)
  );

  // R2: a single-pulse frame never raises the end strobe
  p_single_no_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start && mode_i == MODE_SINGLE) |=> !seq_active);

  // R6: the end strobe is one cycle wide
  p_done_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |=> !burst_done_o);

endmodule

// File: tb/lpg_link_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module lpg_link_pulse_gen_tb_top;

  localparam int HZ   = 256_000;
  localparam int SP   = HZ / 8000;                       // 125 us
  localparam int DOFF = (HZ * 62 + 500_000) / 1_000_000; // 62 us
  localparam int PER  = (HZ / 1000) * 16;                // 16 ms
  localparam int PWR  = ((HZ / 1000) * 100 + 500_000) / 1_000_000;
  localparam int PW   = (PWR == 0) ? 1 : PWR;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] code = '0;
  logic        pulse;
  logic        done;

  always #2.5 clk = ~clk;

  lpg_link_pulse_gen #(.CLK_HZ(HZ)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .mode_i       (mode),
    .code_word_i  (code),
    .pulse_o      (pulse),
    .burst_done_o (done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nrise = 0;
  int ndone = 0;
  int done_long = 0;
  int cur_w = 0;
  int prev_t0 = -1;
  bit p_q = 1'b0;
  bit d_q = 1'b0;
  int rise_t [0:2047];
  int wid    [0:2047];
  int done_t [0:255];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse && !p_q) begin
        if (nrise < 2048) rise_t[nrise] = cyc;
        nrise++;
        cur_w = 1;
      end else if (pulse && p_q) begin
        cur_w++;
      end else if (!pulse && p_q && nrise <= 2048) begin
        wid[nrise-1] = cur_w;
      end
      if (done && !d_q) begin
        if (ndone < 256) done_t[ndone] = cyc;
        ndone++;
      end else if (done && d_q) begin
        done_long++;
      end
      p_q = pulse;
      d_q = done;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit near(int a, int b);
    return (a - b <= 1) && (b - a <= 1);
  endfunction

  // one burst: expected word w; optionally scramble the input mid-burst
  task automatic flp_burst(input logic [15:0] w, input bit flip);
    int m, d, j, bad, nexp, t0, jl, wbad;
    code = w;
    m = nrise;
    d = ndone;
    wait (nrise > m);
    if (flip) begin
      repeat (40) @(negedge clk);
      code = ~w;
    end
    wait (ndone > d);
    @(negedge clk);
    t0 = rise_t[m];
    nexp = 17 + $countones(w);
    chk(nrise - m == nexp, flip ? "R7" : "R3", "pulses in burst", nrise - m, nexp);
    j = m; bad = 0; jl = m;
    for (int k = 0; k < 17; k++) begin
      if (!near(rise_t[j], t0 + k * SP)) bad++;
      jl = j;
      j++;
      if (k < 16 && w[k]) begin
        if (!near(rise_t[j], t0 + k * SP + DOFF)) bad++;
        j++;
      end
    end
    chk(bad == 0, flip ? "R7" : "R4", "misplaced pulses", bad, 0);
    chk(done_t[d] - rise_t[jl] == PW, "R6", "strobe after last clock", done_t[d] - rise_t[jl], PW);
    chk(ndone - d == 1, "R6", "strobes per burst", ndone - d, 1);
    wbad = 0;
    for (int i = m; i < nrise; i++) if (wid[i] != PW) wbad++;
    chk(wbad == 0, "R1", "pulse widths off", wbad, 0);
    if (prev_t0 >= 0) chk(t0 - prev_t0 == PER, "R5", "frame spacing", t0 - prev_t0, PER);
    prev_t0 = t0;
  endtask

  initial begin : watchdog
    repeat (190_000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int e0, m, d;
    repeat (10) @(negedge clk);
    chk(pulse == 1'b0 && done == 1'b0, "R1", "outputs in reset", {pulse, done}, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(nrise == 0 && ndone == 0, "R8", "idle without enable", nrise + ndone, 0);

    // single-pulse mode
    mode = 1'b0;
    en = 1'b1;
    e0 = cyc;
    wait (nrise == 1);
    chk(rise_t[0] - e0 == 2, "R8", "first pulse after enable", rise_t[0] - e0, 2);
    wait (nrise == 4);
    repeat (PW + 2) @(negedge clk);
    for (int i = 1; i < 4; i++)
      chk(rise_t[i] - rise_t[i-1] == PER, "R2", "single pulse spacing", rise_t[i] - rise_t[i-1], PER);
    chk(wid[0] == PW && wid[3] == PW, "R1", "single pulse width", wid[3], PW);
    chk(ndone == 0, "R2", "no strobe in single mode", ndone, 0);

    // switch to bursts; first burst one frame after last single pulse
    mode = 1'b1;
    prev_t0 = rise_t[3];
    m = nrise;
    flp_burst(16'h0000, 1'b0);
    chk(rise_t[m+1] - rise_t[m] == SP, "R9", "clock spacing from CLK_HZ", rise_t[m+1] - rise_t[m], SP);
    flp_burst(16'hFFFF, 1'b0);
    chk(rise_t[m+18] - rise_t[m+17] == DOFF, "R9", "data offset from CLK_HZ", rise_t[m+18] - rise_t[m+17], DOFF);
    flp_burst(16'hAAAA, 1'b0);
    flp_burst(16'h5555, 1'b0);
    for (int b = 0; b < 16; b++) flp_burst(16'h0001 << b, 1'b0);
    flp_burst(16'hA5C3, 1'b1);

    // enable dropped during a burst
    code = 16'h00FF;
    m = nrise;
    d = ndone;
    wait (nrise > m);
    @(negedge clk);
    en = 1'b0;
    wait (ndone > d);
    @(negedge clk);
    chk(nrise - m == 25, "R8", "burst completes after disable", nrise - m, 25);
    m = nrise;
    d = ndone;
    repeat (2 * PER) @(negedge clk);
    chk(nrise == m && ndone == d, "R8", "quiet after disable", nrise - m + ndone - d, 0);
    chk(pulse == 1'b0, "R8", "output held low", pulse, 0);

    en = 1'b1;
    e0 = cyc;
    repeat (5) @(negedge clk);
    chk(nrise == m + 1, "R8", "restart pulse count", nrise - m, 1);
    chk(rise_t[m] - e0 == 2, "R8", "restart latency", rise_t[m] - e0, 2);
    wait (ndone > d);
    @(negedge clk);
    chk(done_long == 0, "R6", "strobe longer than one cycle", done_long, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule